// File: doc/BRIEF.md
# Multi-channel run-length transition encoder

This block watches a parallel word of probe channels and turns it into a compact stream of run lengths. All channels are registered together in one clock cycle, so no channel is skewed against another. A free-running timer paces the sampling. On each sample strobe the new word is XORed against the word taken at the previous strobe. A channel that kept its level extends its run counter. A channel that changed level gives up its finished run as a record, and its counter starts again.

A long run does not need a wide count. When a counter reaches the programmed run limit, the block emits an overflow marker for that channel and restarts the count. A run is therefore decoded as (markers × limit) + final count. The records of one sample go to a small FIFO one at a time, lowest channel index first. The FIFO feeds a valid/ready output. A record is transferred on every rising clock edge where `rec_valid` and `rec_ready` are both high. While `rec_ready` is low the head record stays on `rec_data` and does not change. The sink may hold `rec_ready` low for as long as it needs. If that delays the records of one sample until the next strobe arrives, the block raises a sticky overrun flag and stops counting.

Software pulses `start` to begin a capture and `stop` to end it. On `stop`, every channel's partial run is flushed out, and only after that does `busy` fall. `sample_period` and `run_limit` must stay constant while `busy` is high.

Top module: `rle_transition_encoder`

## Requirements
- R1: After reset `busy`, `overrun` and `rec_valid` are low.
- R2: A `start` pulse while idle sets `busy` and starts the timer. Samples are taken every `sample_period` cycles, with 0 treated as 1. Each sample uses the word registered one cycle before the strobe, with all channels captured in the same cycle.
- R3: The first sample after start emits no record. It loads the reference word and sets every channel's count to 1.
- R4: When a channel's level differs from the previous sample, the block emits a final record for that channel with type bit 1 and count equal to its run length in samples. The channel's count then restarts at 1.
- R5: Records from one sample leave in ascending channel order, and the records of an earlier sample leave before those of a later sample.
- R6: When a channel holds its level, its count is incremented. If the incremented count reaches a nonzero `run_limit`, the block emits a marker record with type bit 0 and count equal to `run_limit`, and the channel's count becomes 0.
- R7: When `run_limit` is 0 the block emits no marker records, and counters saturate at all ones.
- R8: A strobe that arrives while records of the previous sample are still waiting to enter the FIFO sets `overrun`. Once `overrun` is set, no later sample is counted. `overrun` stays set until the next accepted `start`.
- R9: A `stop` pulse during a capture first lets pending records drain. The block then emits one final record per channel, in ascending order, carrying that channel's partial count. `busy` falls only after the last record has been taken. A `stop` before the first sample returns the block to idle with no records.
- R10: While `rec_valid` is high and `rec_ready` is low, `rec_valid` stays high and `rec_data` does not change.
- R11: Record layout: bits [47:43] hold the channel index, bit [42] the type (1 = final, 0 = marker), bits [41:40] are 0, and bits [39:0] hold the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a capture (accepted when idle) |
| stop | input | 1 | End a capture and flush partial runs |
| sample_period | input | 16 | Cycles between sample strobes |
| run_limit | input | 40 | Count at which a marker is emitted; 0 disables markers |
| probe_word | input | 32 | Parallel channel levels |
| busy | output | 1 | Capture or flush in progress |
| overrun | output | 1 | Sticky: records were not drained in time |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Sink accepts the record |
| rec_data | output | 48 | Record: index, type, reserved, count |

## Verification
In one sample, one channel can reach its run limit while another channel changes level. That sample then carries both a marker and a final record, and the two must still leave in channel order. The bench provokes this case by holding most channels long enough to hit a limit of 3 while toggling a few others on the same sample. It also applies random back-pressure and checks every record against an ordered scoreboard model. A second clash is a strobe landing while the previous sample's records are still stalled. The bench forces this with a short period and `rec_ready` held low. It then confirms that `overrun` rises and that the counts flushed later ignore the dropped samples.

// File: rtl/rle_enc_pkg.sv
`timescale 1ns/1ps
package rle_enc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FIRST = 3'd1,
    ST_RUN   = 3'd2,
    ST_STOP  = 3'd3,
    ST_FLUSH = 3'd4
  } enc_state_e;

  localparam int RSV_W = 2;
endpackage

// File: rtl/rle_period_timer.sv
`timescale 1ns/1ps
module rle_period_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             strobe
);
  logic [PER_W-1:0] tick_q;
  logic [PER_W-1:0] last_tick;

  assign last_tick = (period == '0) ? '0 : period - PER_W'(1);
  assign strobe    = run && (tick_q == last_tick);

  always_ff @(posedge clk) begin
    if (!rst_n)             tick_q <= '0;
    else if (!run || strobe) tick_q <= '0;
    else                     tick_q <= tick_q + PER_W'(1);
  end
endmodule

// File: rtl/rle_chan_bank.sv
`timescale 1ns/1ps
module rle_chan_bank #(
  parameter int NCH   = 32,
  parameter int CNT_W = 40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             probe_word,
  input  logic                       first_take,
  input  logic                       step,
  input  logic [CNT_W-1:0]           run_limit,
  output logic [NCH-1:0]             ev_mask,
  output logic [NCH-1:0]             ev_final,
  output logic [NCH-1:0][CNT_W-1:0]  ev_cnt,
  output logic [NCH-1:0][CNT_W-1:0]  live_cnt
);
  logic [NCH-1:0] cur_q;
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] chg;
  logic           limit_on;

  assign chg      = cur_q ^ prev_q;
  assign limit_on = |run_limit;

  // All channels are registered in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q <= probe_word;
      if (first_take || step) prev_q <= cur_q;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] inc;
    logic             hit;

    assign inc = cnt_q + CNT_W'(1);
    assign hit = limit_on && (inc >= run_limit);

    assign ev_mask[g]  = chg[g] | hit;
    assign ev_final[g] = chg[g];
    assign ev_cnt[g]   = chg[g] ? cnt_q : run_limit;
    assign live_cnt[g] = cnt_q;

    always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (first_take) cnt_q <= CNT_W'(1);
      else if (step) begin
        if (chg[g])                      cnt_q <= CNT_W'(1);
        else if (hit)                    cnt_q <= '0;
        else if (!limit_on && &cnt_q)    cnt_q <= cnt_q;
        else                             cnt_q <= inc;
      end
    end
  end
endmodule

// File: rtl/rle_rec_serializer.sv
`timescale 1ns/1ps
module rle_rec_serializer #(
  parameter int NCH   = 32,
  parameter int CNT_W = 40,
  parameter int IDX_W = 5,
  parameter int REC_W = 48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [NCH-1:0]            ld_mask,
  input  logic [NCH-1:0]            ld_final,
  input  logic [NCH-1:0][CNT_W-1:0] ld_cnt,
  input  logic                      fifo_full,
  output logic                      pend_any,
  output logic                      push,
  output logic [REC_W-1:0]          push_rec
);
  import rle_enc_pkg::*;

  logic [NCH-1:0]            pend_q;
  logic [NCH-1:0]            fin_q;
  logic [NCH-1:0][CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0]          sel;

  // Lowest pending channel wins.
  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = IDX_W'(i);
    end
  end

  assign pend_any = |pend_q;
  assign push     = pend_any && !fifo_full;
  assign push_rec = {sel, fin_q[sel], {RSV_W{1'b0}}, cnt_q[sel]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      fin_q  <= '0;
      cnt_q  <= '0;
    end else if (ld_en) begin
      pend_q <= ld_mask;
      fin_q  <= ld_final;
      cnt_q  <= ld_cnt;
    end else if (push) begin
      pend_q[sel] <= 1'b0;
    end
  end
endmodule

// File: rtl/rle_rec_fifo.sv
`timescale 1ns/1ps
module rle_rec_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   fill_q;
  logic          do_push, do_pop;

  assign full    = (fill_q == (AW+1)'(DEPTH));
  assign empty   = (fill_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      if (do_push && !do_pop)      fill_q <= fill_q + (AW+1)'(1);
      else if (do_pop && !do_push) fill_q <= fill_q - (AW+1)'(1);
    end
  end
endmodule

// File: rtl/rle_transition_encoder.sv
`timescale 1ns/1ps
module rle_transition_encoder #(
  parameter int  NCH        = 32,
  parameter int  CNT_W      = 40,
  parameter int  PER_W      = 16,
  parameter int  FIFO_DEPTH = 8,
  localparam int IDX_W      = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int REC_W      = IDX_W + 3 + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [PER_W-1:0] sample_period,
  input  logic [CNT_W-1:0] run_limit,
  input  logic [NCH-1:0]   probe_word,
  output logic             busy,
  output logic             overrun,
  output logic             rec_valid,
  input  logic             rec_ready,
  output logic [REC_W-1:0] rec_data
);
  import rle_enc_pkg::*;

  enc_state_e st_q;
  logic       tick_run, strobe;
  logic       first_take, step, flush_load, ld_en;
  logic       pend_any, push, fifo_full, fifo_empty;
  logic [REC_W-1:0] push_rec;

  logic [NCH-1:0]            ev_mask, ev_final, ld_mask, ld_final;
  logic [NCH-1:0][CNT_W-1:0] ev_cnt, live_cnt, ld_cnt;

  assign tick_run   = (st_q == ST_FIRST) || (st_q == ST_RUN);
  assign first_take = (st_q == ST_FIRST) && strobe && !stop;
  assign step       = (st_q == ST_RUN) && strobe && !stop && !pend_any && !overrun;
  assign flush_load = (st_q == ST_STOP) && !pend_any;
  assign ld_en      = step || flush_load;
  assign busy       = (st_q != ST_IDLE);

  rle_period_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tick_run), .period(sample_period), .strobe(strobe)
  );

  rle_chan_bank #(.NCH(NCH), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .probe_word(probe_word),
    .first_take(first_take), .step(step), .run_limit(run_limit),
    .ev_mask(ev_mask), .ev_final(ev_final), .ev_cnt(ev_cnt), .live_cnt(live_cnt)
  );

  always_comb begin
    if (flush_load) begin
      ld_mask  = '1;
      ld_final = '1;
      ld_cnt   = live_cnt;
    end else begin
      ld_mask  = ev_mask;
      ld_final = ev_final;
      ld_cnt   = ev_cnt;
    end
  end

  rle_rec_serializer #(.NCH(NCH), .CNT_W(CNT_W), .IDX_W(IDX_W), .REC_W(REC_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_mask(ld_mask), .ld_final(ld_final),
    .ld_cnt(ld_cnt), .fifo_full(fifo_full), .pend_any(pend_any), .push(push),
    .push_rec(push_rec)
  );

  rle_rec_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_rec), .full(fifo_full),
    .pop(rec_ready), .dout(rec_data), .empty(fifo_empty)
  );

  assign rec_valid = !fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      overrun <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_FIRST;
          overrun <= 1'b0;
        end
        ST_FIRST: begin
          if (stop)        st_q <= ST_IDLE;
          else if (strobe) st_q <= ST_RUN;
        end
        ST_RUN: begin
          if (stop) st_q <= ST_STOP;
          else if (strobe && (pend_any || overrun)) overrun <= 1'b1;
        end
        ST_STOP:  if (!pend_any) st_q <= ST_FLUSH;
        ST_FLUSH: if (!pend_any && fifo_empty) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rle_enc_checker.sv
`timescale 1ns/1ps
module rle_enc_checker #(
  parameter int NCH   = 32,
  parameter int CNT_W = 40,
  parameter int REC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             overrun,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [REC_W-1:0] rec_data,
  input logic [CNT_W-1:0] run_limit
);
  a_r10_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_data));

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !(start && !busy) |=> overrun);

  a_r8_overrun_cleared_by_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> !overrun);

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rec_valid);

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_data[CNT_W+1:CNT_W] == 2'b00);

  a_r7_marker_needs_limit: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_data[CNT_W+2] |-> run_limit != '0);
endmodule

bind rle_transition_encoder rle_enc_checker #(.NCH(NCH), .CNT_W(CNT_W), .REC_W(REC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .overrun(overrun),
  .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data), .run_limit(run_limit)
);

// File: tb/rle_transition_encoder_bench.sv
`timescale 1ns/1ps
module rle_transition_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0;
  logic [15:0] sample_period = 16'd4;
  logic [39:0] run_limit = '0;
  logic [31:0] probe_word = '0;
  logic        busy, overrun, rec_valid, rec_ready;
  logic [47:0] rec_data;

  int checks = 0, fails = 0;
  int ready_mode = 1;
  logic [47:0] exp_q[$];
  string       tag_q[$];

  logic [39:0] m_cnt [32];
  logic [31:0] m_prev;
  bit          m_first;

  always #2.5 clk = ~clk;

  rle_transition_encoder u_rle_transition_encoder (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .sample_period(sample_period), .run_limit(run_limit), .probe_word(probe_word),
    .busy(busy), .overrun(overrun), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_data(rec_data)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Ready driver: 0 = held low, 1 = held high, 2 = pseudo-random.
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    rec_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rec_ready = (ready_mode == 1) ? 1'b1 : (ready_mode == 2) ? lfsr[0] : 1'b0;
    end
  end

  // Monitor: a record moves on the edge after a negedge that sees valid && ready.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rec_valid && rec_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected record", rec_data, '0);
        end else begin
          logic [47:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rec_data === e, t, rec_data, e);
        end
      end
    end
  end

  function automatic void expect_rec(input int ch, input bit fin, input logic [39:0] c,
                                     input string t);
    exp_q.push_back({5'(ch), fin, 2'b00, c});
    tag_q.push_back(t);
  endfunction

  // Reference model of one sample (R3, R4, R5, R6, R7).
  function automatic void model_sample(input logic [31:0] w);
    if (m_first) begin
      m_first = 1'b0;
      m_prev  = w;
      for (int i = 0; i < 32; i++) m_cnt[i] = 40'd1;
      return;
    end
    for (int i = 0; i < 32; i++) begin
      if (w[i] != m_prev[i]) begin
        expect_rec(i, 1'b1, m_cnt[i], "R4 R5 final run");
        m_cnt[i] = 40'd1;
      end else begin
        logic [39:0] n;
        n = m_cnt[i] + 40'd1;
        if (run_limit != 0 && n >= run_limit) begin
          expect_rec(i, 1'b0, run_limit, "R6 R11 marker");
          m_cnt[i] = 40'd0;
        end else begin
          m_cnt[i] = n;
        end
      end
    end
    m_prev = w;
  endfunction

  task automatic do_start();
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    m_first = 1'b1;
  endtask

  task automatic take(input logic [31:0] w, input bit counted);
    if (counted) model_sample(w);
    probe_word = w;
    repeat (int'(sample_period)) @(posedge clk);
    #1;
  endtask

  task automatic do_stop(input bit flush);
    if (flush) begin
      for (int i = 0; i < 32; i++) expect_rec(i, 1'b1, m_cnt[i], "R9 flush");
    end
    stop = 1'b1;
    @(posedge clk); #1;
    stop = 1'b0;
  endtask

  task automatic wait_idle_and_check(input string req);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, req, 48'(exp_q.size()), 48'd0);
  endtask

  initial begin
    repeat (30000 * 5) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: busy=%0b expected run to finish", busy);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0,      "R1 busy", 48'(busy), 48'd0);
    check(overrun == 1'b0,   "R1 overrun", 48'(overrun), 48'd0);
    check(rec_valid == 1'b0, "R1 rec_valid", 48'(rec_valid), 48'd0);
    @(posedge clk); #1;

    // Phase A: limit 3, random back-pressure; markers and finals share samples.
    ready_mode    = 2;
    sample_period = 16'd120;
    run_limit     = 40'd3;
    do_start();
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after start", 48'(busy), 48'd1);
    @(posedge clk); #1;
    // Realign: one extra cycle elapsed, so restart the capture cleanly.
    do_stop(1'b0);
    wait_idle_and_check("R9 stop before first sample");
    @(posedge clk); #1;
    do_start();
    take(32'h0000_0000, 1'b1);
    take(32'h0000_0000, 1'b1);
    take(32'h0000_0000, 1'b1);
    take(32'h0000_00FF, 1'b1);
    take(32'h0000_00FF, 1'b1);
    take(32'h0F0F_00F0, 1'b1);
    take(32'h0F0F_00F0, 1'b1);
    take(32'h0F0F_00F0, 1'b1);
    take(32'hF0F0_FF0F, 1'b1);
    take(32'hF0F0_FF0F, 1'b1);
    take(32'h8000_0001, 1'b1);
    check(overrun == 1'b0, "R8 no overrun when drained", 48'(overrun), 48'd0);
    do_stop(1'b1);
    check(busy == 1'b1, "R9 busy during flush", 48'(busy), 48'd1);
    wait_idle_and_check("R9 all records taken before busy falls");

    // Phase B: limit 0, a long run emits no markers (R7).
    ready_mode    = 1;
    sample_period = 16'd100;
    run_limit     = 40'd0;
    @(posedge clk); #1;
    do_start();
    take(32'h0000_0001, 1'b1);
    for (int k = 0; k < 6; k++) take(32'h0000_0001, 1'b1);
    take(32'h0000_0003, 1'b1);
    take(32'h0000_0002, 1'b1);
    do_stop(1'b1);
    wait_idle_and_check("R7 R9 unlimited run");

    // Phase C: short period with a stalled sink forces overrun (R8).
    ready_mode    = 0;
    sample_period = 16'd4;
    run_limit     = 40'd4;
    @(posedge clk); #1;
    do_start();
    take(32'h0000_0000, 1'b1);
    take(32'hFFFF_FFFF, 1'b1);
    take(32'h0000_0000, 1'b0);
    take(32'hFFFF_FFFF, 1'b0);
    @(negedge clk);
    check(overrun == 1'b1, "R8 overrun set", 48'(overrun), 48'd1);
    @(posedge clk); #1;
    ready_mode = 1;
    do_stop(1'b1);
    wait_idle_and_check("R8 R9 dropped samples not counted");
    check(overrun == 1'b1, "R8 overrun sticky while idle", 48'(overrun), 48'd1);
    @(posedge clk); #1;
    do_start();
    @(negedge clk);
    check(overrun == 1'b0, "R8 overrun cleared by start", 48'(overrun), 48'd0);
    @(posedge clk); #1;
    do_stop(1'b0);
    wait_idle_and_check("R3 R9 no records without samples");
    check(busy == 1'b0, "R9 idle after early stop", 48'(busy), 48'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule